// File: doc/BRIEF.md
# External Interrupt Sense Unit

This unit turns activity on two external interrupt pins into interrupt requests for a CPU. Both pins pass through a clocked synchroniser. A single two-bit sense mode, shared by both pins, sets what counts as an event. The four choices are a held low level, any change, a falling edge, or a rising edge. Edge and change events are stored in a sticky flag for each pin. The flag stays set until the CPU acknowledges that pin. Low-level mode stores nothing. Its request follows the synchronised pin level for as long as the pin stays low.

A request reaches the CPU only when the pin's own enable bit is set and the global interrupt-enable input is high. Software reaches two 8-bit registers through a plain read/write port. The sense register holds the mode and the enable register holds the two per-pin enables. Reads are combinational. The unit watches the pad value directly, so a pin that the chip drives as an output still raises requests.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, both registers read 0x00 and both request outputs are low.
- R2: The sense register is at address 0x35. Bits 1:0 hold the mode: 00 is low level, 01 is any change, 10 is falling edge and 11 is rising edge. Bits 7:2 read as 0 whatever was written to them.
- R3: The enable register is at address 0x3B. Bit 6 enables pin 0 and bit 7 enables pin 1. All other bits of this register read as 0. Any other address reads 0x00.
- R4: In mode 00, the request for a pin is high exactly while its synchronised level is low. A pin that goes low before clock edge N raises the request after edge N+1. The request drops after edge N+1 of the return to high, and nothing is latched.
- R5: In mode 01, a change on a pin just before clock edge N sets that pin's flag at edge N+2. The request is low after edges N and N+1 and high after edge N+2.
- R6: Mode 10 sets the flag only on a high-to-low transition, and mode 11 only on a low-to-high transition. The opposite transition leaves the request low.
- R7: A flag stays set until the acknowledge bit for that pin is high at a clock edge. If a new event arrives at the same edge as the acknowledge, the event wins.
- R8: A request is high only when the pin's enable bit and the global enable are both high. A flag set while the request is masked is kept, and it shows up once the request is unmasked.
- R9: In modes 01, 10 and 11, a pulse that holds its level across one sampling clock edge sets the flag.
- R10: Writing a new mode while both pins are steady sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, sampled at the clock edge |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| pin_i | input | 2 | Raw pad values of pins 1 and 0, asynchronous |
| gie_i | input | 1 | Global interrupt enable from the CPU |
| ack_i | input | 2 | Per-pin flag clear from the CPU |
| irq_o | output | 2 | Per-pin request toward the CPU |

## Verification
The assertions treat the register write strobe, the acknowledge bits and the global enable as synchronous to clk. They take the pin inputs as asynchronous, and they observe pins only after the synchroniser. The bench drives every input on the falling clock edge. This keeps each value stable across the sampling edge, and it keeps pulses at least one full period wide, which is the minimum width the edge rules assume. Mode writes happen while the pins are quiet, except where a requirement calls for overlap.

// File: rtl/eis_pkg.sv
// Shared types for the external interrupt sense unit.
// Assumes nothing beyond the 2-bit mode encoding fixed by the register layout.
package eis_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

endpackage

// File: rtl/eis_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
// Assumes STAGES >= 2. Every stage resets to 0.
module eis_sync #(
    parameter int NPINS  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [NPINS-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the pin sample one stage deeper on each clock.
            always_ff @(posedge clk) begin
                if (!rst_n)      stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= pin_i;
                else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[LAST];
endmodule

// File: rtl/eis_detect.sv
// Event detector for one synchronised pin.
// Keeps the previous sample, decodes the shared sense mode and holds a
// sticky flag that is cleared by acknowledge. A new event wins over acknowledge.
// Assumes sync_i is already synchronous to clk.
module eis_detect
    import eis_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_e mode_i,
    input  logic   sync_i,
    input  logic   ack_i,
    output logic   prev_o,
    output logic   flag_o,
    output logic   req_o
);
    logic prev_q;
    logic flag_q;
    logic hit;

    // Purpose: decode the selected edge condition from the current and previous samples.
    always_comb begin
        case (mode_i)
            SENSE_ANY:  hit = sync_i ^ prev_q;
            SENSE_FALL: hit = prev_q & ~sync_i;
            SENSE_RISE: hit = ~prev_q & sync_i;
            default:    hit = 1'b0;
        endcase
    end

    // Purpose: track the previous sample and update the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= sync_i;
            flag_q <= hit | (flag_q & ~ack_i);
        end
    end

    assign prev_o = prev_q;
    assign flag_o = flag_q;
    assign req_o  = (mode_i == SENSE_LOW) ? ~sync_i : flag_q;
endmodule

// File: rtl/eis_regs.sv
// Sense-mode and pin-enable registers behind an 8-bit read/write port.
// Assumes that a write and a read of the same cycle are decoded from one address.
module eis_regs
    import eis_pkg::*;
#(
    parameter int             NPINS     = 2,
    parameter int             ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h35,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 6'h3B,
    parameter int             MASK_LSB  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              we_i,
    output logic [7:0]        rdata_o,
    output sense_e            mode_o,
    output logic [NPINS-1:0]  en_o
);
    localparam int MODE_W = $bits(sense_e);

    sense_e           mode_q;
    logic [NPINS-1:0] en_q;

    // Purpose: capture register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SENSE_LOW;
            en_q   <= '0;
        end else if (we_i) begin
            if (addr_i == CTRL_ADDR) mode_q <= sense_e'(wdata_i[MODE_W-1:0]);
            if (addr_i == MASK_ADDR) en_q   <= wdata_i[MASK_LSB +: NPINS];
        end
    end

    // Purpose: combinational read mux. Unused bits and addresses return 0.
    always_comb begin
        rdata_o = '0;
        if (addr_i == CTRL_ADDR) rdata_o[MODE_W-1:0]       = mode_q;
        if (addr_i == MASK_ADDR) rdata_o[MASK_LSB +: NPINS] = en_q;
    end

    assign mode_o = mode_q;
    assign en_o   = en_q;
endmodule

// File: rtl/ext_irq_sense.sv
// Top of the external interrupt sense unit.
// Synchronises the pins, detects events per pin under one shared mode, and
// gates each request with its enable bit and the global enable.
// Assumes gie_i, ack_i and the register port are synchronous to clk.
module ext_irq_sense
    import eis_pkg::*;
#(
    parameter int NPINS       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_we,
    output logic [7:0]        reg_rdata,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              gie_i,
    input  logic [NPINS-1:0]  ack_i,
    output logic [NPINS-1:0]  irq_o
);
    sense_e           sense_mode;
    logic [NPINS-1:0] pin_en;
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] pin_prev;
    logic [NPINS-1:0] pin_flag;
    logic [NPINS-1:0] pin_req;

    eis_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(reg_addr), .wdata_i(reg_wdata),
        .we_i(reg_we), .rdata_o(reg_rdata), .mode_o(sense_mode), .en_o(pin_en)
    );

    eis_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sync_o(pin_sync)
    );

    genvar p;
    generate
        for (p = 0; p < NPINS; p++) begin : g_pin
            eis_detect u_det (
                .clk(clk), .rst_n(rst_n), .mode_i(sense_mode),
                .sync_i(pin_sync[p]), .ack_i(ack_i[p]),
                .prev_o(pin_prev[p]), .flag_o(pin_flag[p]), .req_o(pin_req[p])
            );
        end
    endgenerate

    assign irq_o = pin_req & pin_en & {NPINS{gie_i}};
endmodule

// File: rtl/eis_checker.sv
// Property checker for ext_irq_sense, attached with bind.
// Assumes every observed input is synchronous to clk.
module eis_checker
    import eis_pkg::*;
#(
    parameter int NPINS  = 2,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input sense_e            mode,
    input logic [NPINS-1:0]  sync,
    input logic [NPINS-1:0]  prev,
    input logic [NPINS-1:0]  flag,
    input logic [NPINS-1:0]  en,
    input logic [NPINS-1:0]  ack,
    input logic [NPINS-1:0]  irq,
    input logic              gie,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata
);
    // R2: unused bits of the sense register read as zero
    assert_ctrl_unused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 6'h35) |-> (rdata[7:2] == 6'b0));

    // R8: no request while the global enable is low
    assert_gie_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> (irq == '0));

    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_chk
            // R4: low-level mode never requests while the pin is high
            assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == SENSE_LOW && sync[i]) |-> !irq[i]);
            // R5: a change in any-change mode sets the flag at the next edge
            assert_any_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == SENSE_ANY && (sync[i] != prev[i])) |=> flag[i]);
            // R6: a falling transition in falling mode sets the flag
            assert_fall_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == SENSE_FALL && prev[i] && !sync[i]) |=> flag[i]);
            // R7: a flag without acknowledge stays set
            assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (flag[i] && !ack[i]) |=> flag[i]);
            // R8: a request needs the pin enable
            assert_en_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
                irq[i] |-> en[i]);
        end
    endgenerate
endmodule

bind ext_irq_sense eis_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(sense_mode), .sync(pin_sync),
    .prev(pin_prev), .flag(pin_flag), .en(pin_en), .ack(ack_i),
    .irq(irq_o), .gie(gie_i), .addr(reg_addr), .rdata(reg_rdata)
);

// File: tb/ext_irq_sense_test.sv
module ext_irq_sense_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic [1:0] pin_i = 2'b11;
    logic       gie_i = 1'b0;
    logic [1:0] ack_i = 2'b00;
    logic [1:0] irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ext_irq_sense uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .pin_i(pin_i), .gie_i(gie_i),
        .ack_i(ack_i), .irq_o(irq_o)
    );

    // Behavioural reference: pin sample history, mode, enables, flags
    int   h1 [2], h2 [2], h3 [2];
    int   m_mode;
    bit   m_en [2];
    bit   m_flag [2];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0;
            for (int i = 0; i < 2; i++) begin
                h1[i] = 0; h2[i] = 0; h3[i] = 0; m_en[i] = 0; m_flag[i] = 0;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                bit ev;
                ev = (m_mode == 1 && h2[i] != h3[i]) ||
                     (m_mode == 2 && h3[i] == 1 && h2[i] == 0) ||
                     (m_mode == 3 && h3[i] == 0 && h2[i] == 1);
                m_flag[i] = ev || (m_flag[i] && !ack_i[i]);
                h3[i] = h2[i];
                h2[i] = h1[i];
                h1[i] = int'(pin_i[i]);
            end
            if (reg_we && reg_addr == 6'h35) m_mode = int'(reg_wdata[1:0]);
            if (reg_we && reg_addr == 6'h3B) begin
                m_en[0] = reg_wdata[6];
                m_en[1] = reg_wdata[7];
            end
        end
    end

    function automatic logic [1:0] model_irq();
        logic [1:0] r;
        for (int i = 0; i < 2; i++) begin
            bit src;
            src = (m_mode == 0) ? (h2[i] == 0) : m_flag[i];
            r[i] = src && m_en[i] && gie_i;
        end
        return r;
    endfunction

    // Per-cycle comparison against the reference (R4 R5 R6 R7 R8 by mode)
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [1:0] exp;
            exp = model_irq();
            checks++;
            if (irq_o !== exp) begin
                failures++;
                $display("FAIL cycle compare mode=%0d (R4 R5 R6 R7 R8): irq actual=%b expected=%b",
                         m_mode, irq_o, exp);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(string tag, logic [5:0] a, logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #2;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic irq_is(string tag, logic [1:0] exp);
        #2;
        chk(tag, {6'b0, irq_o}, {6'b0, exp});
    endtask

    task automatic ack(logic [1:0] a);
        @(negedge clk);
        ack_i = a;
        @(negedge clk);
        ack_i = 2'b00;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(5);
        // R1: reset state
        rd("R1 sense reg reset", 6'h35, 8'h00);
        rd("R1 enable reg reset", 6'h3B, 8'h00);
        irq_is("R1 irq reset", 2'b00);

        // R2: sense register layout
        wr(6'h35, 8'hFF);
        rd("R2 sense reg unused bits", 6'h35, 8'h03);
        // R3: enable register layout
        wr(6'h3B, 8'hFF);
        rd("R3 enable reg bits", 6'h3B, 8'hC0);
        wr(6'h3B, 8'h40);
        rd("R3 pin0 enable at bit 6", 6'h3B, 8'h40);
        wr(6'h3B, 8'hFF);
        rd("R3 unmapped address", 6'h10, 8'h00);

        // R10: mode writes with steady pins
        @(negedge clk); gie_i = 1'b1;
        wr(6'h35, 8'h02);
        wr(6'h35, 8'h03);
        wr(6'h35, 8'h01);
        tick(3);
        irq_is("R10 mode change alone", 2'b00);

        // R5: any-change timing on pin 0
        @(negedge clk); pin_i[0] = 1'b0;
        tick(2);
        irq_is("R5 not yet after two edges", 2'b00);
        tick(1);
        irq_is("R5 request after third edge", 2'b01);
        tick(5);
        irq_is("R7 flag sticky", 2'b01);
        ack(2'b01);
        irq_is("R7 acknowledge clears", 2'b00);
        @(negedge clk); pin_i[0] = 1'b1;
        tick(4);
        irq_is("R5 rising change also counts", 2'b01);
        ack(2'b01);

        // R6: falling mode on pin 1
        wr(6'h35, 8'h02);
        @(negedge clk); pin_i[1] = 1'b0;
        tick(4);
        irq_is("R6 falling edge in mode 10", 2'b10);
        ack(2'b10);
        @(negedge clk); pin_i[1] = 1'b1;
        tick(4);
        irq_is("R6 rising ignored in mode 10", 2'b00);

        // R6: rising mode on pin 1
        wr(6'h35, 8'h03);
        @(negedge clk); pin_i[1] = 1'b0;
        tick(4);
        irq_is("R6 falling ignored in mode 11", 2'b00);
        @(negedge clk); pin_i[1] = 1'b1;
        tick(4);
        irq_is("R6 rising edge in mode 11", 2'b10);
        ack(2'b10);

        // R8: masking keeps the flag
        wr(6'h35, 8'h01);
        wr(6'h3B, 8'h00);
        @(negedge clk); pin_i[0] = 1'b0;
        tick(4);
        irq_is("R8 masked by enable bit", 2'b00);
        wr(6'h3B, 8'h40);
        irq_is("R8 flag appears once unmasked", 2'b01);
        @(negedge clk); gie_i = 1'b0;
        irq_is("R8 masked by global enable", 2'b00);
        @(negedge clk); gie_i = 1'b1;
        irq_is("R8 global enable restored", 2'b01);
        ack(2'b01);
        @(negedge clk); pin_i[0] = 1'b1;
        tick(4);
        ack(2'b01);
        wr(6'h3B, 8'hC0);

        // R4: low level, non-latching
        wr(6'h35, 8'h00);
        tick(2);
        @(negedge clk); pin_i[0] = 1'b0;
        tick(1);
        irq_is("R4 not yet after first edge", 2'b00);
        tick(1);
        irq_is("R4 low level requests", 2'b01);
        ack(2'b01);
        irq_is("R4 acknowledge has no effect on level", 2'b01);
        @(negedge clk); pin_i[0] = 1'b1;
        tick(2);
        irq_is("R4 request drops with level", 2'b00);

        // R9: one-cycle pulses
        wr(6'h35, 8'h01);
        tick(3);
        @(negedge clk); pin_i[1] = 1'b0;
        @(negedge clk); pin_i[1] = 1'b1;
        tick(4);
        irq_is("R9 one-cycle pulse in mode 01", 2'b10);
        ack(2'b10);
        tick(1);
        wr(6'h35, 8'h02);
        @(negedge clk); pin_i[0] = 1'b0;
        @(negedge clk); pin_i[0] = 1'b1;
        tick(4);
        irq_is("R9 one-cycle pulse in mode 10", 2'b01);
        ack(2'b01);

        // R7: event wins over a held acknowledge
        wr(6'h35, 8'h01);
        @(negedge clk); ack_i = 2'b01; pin_i[0] = 1'b0;
        tick(3);
        irq_is("R7 set beats acknowledge", 2'b01);
        tick(1);
        irq_is("R7 cleared on next acknowledged edge", 2'b00);
        @(negedge clk); ack_i = 2'b00;
        tick(3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule